// File: doc/BRIEF.md
# Single-Cycle RV32I Control Decoder

This block is the control unit of a single-cycle RV32I core. It looks at the 32-bit instruction word and at the two results of the branch comparator. From these it produces every select and enable that the datapath needs in the same cycle. It has no state. It sits between instruction memory and the register file, ALU, immediate generator, comparator, data memory and PC mux, which are all outside this block.

The outputs are:
- the next-PC source;
- the immediate format;
- the register write enable;
- the unsigned-compare request to the comparator;
- the two ALU operand sources;
- the ALU operation code;
- the data memory direction;
- the register writeback source.

Opcodes outside the supported set give safe outputs: nothing is written and the PC steps sequentially.

Encodings used on the ports:

| Output | Encoding |
|---|---|
| `pc_sel` | 0 = PC+4, 1 = ALU result (jump or branch target) |
| `imm_sel` | 0 = I, 1 = S, 2 = B, 3 = J, 4 = U |
| `a_sel` | 0 = rs1, 1 = PC |
| `b_sel` | 0 = rs2, 1 = immediate |
| `mem_wr` | 0 = read, 1 = write |
| `wb_sel` | 0 = data memory, 1 = ALU, 2 = PC+4 |
| `alu_sel` | 0 add, 1 sub, 2 sll, 3 slt, 4 sltu, 5 xor, 6 srl, 7 sra, 8 or, 9 and, 10 pass-B |

Instruction fields:
- opcode is `instr[6:0]`;
- funct3 is `instr[14:12]`;
- funct7 is `instr[31:25]`.

Top module: `rvdec_top`

## Requirements
- R1: Opcode 0110011 (register-register): `reg_wen`=1, `a_sel`=0, `b_sel`=0, `wb_sel`=1, `pc_sel`=0, `mem_wr`=0, `imm_sel`=0. `alu_sel` comes from funct3: 000 add, 001 sll, 010 slt, 011 sltu, 100 xor, 101 srl, 110 or, 111 and.
- R2: With opcode 0110011 and funct7 = 0100000, funct3 000 gives sub (1) and funct3 101 gives sra (7). Any other funct7 value leaves the base operation.
- R3: Opcode 0010011 (immediate arithmetic): `b_sel`=1, `imm_sel`=0, `reg_wen`=1, `wb_sel`=1, `a_sel`=0. `alu_sel` follows the R1 funct3 table. funct3 000 is always add, even when funct7 = 0100000. funct3 101 with funct7 = 0100000 gives sra.
- R4: Opcode 0000011 (load): `reg_wen`=1, `b_sel`=1, `imm_sel`=0, `alu_sel`=add, `mem_wr`=0, `wb_sel`=0.
- R5: Opcode 0100011 (store): `mem_wr`=1, `reg_wen`=0, `imm_sel`=1, `b_sel`=1, `a_sel`=0, `alu_sel`=add.
- R6: Opcode 1100011 (branch): `a_sel`=1, `b_sel`=1, `imm_sel`=2, `alu_sel`=add, `reg_wen`=0, `mem_wr`=0. `pc_sel`=1 exactly when the condition holds:
  - funct3 000: `br_eq`=1;
  - funct3 001: `br_eq`=0;
  - funct3 100 and 110: `br_lt`=1;
  - funct3 101 and 111: `br_lt`=0;
  - funct3 010 and 011: never taken.
- R7: `br_unsigned` is 1 only for opcode 1100011 with funct3 110 or 111, and 0 for every other instruction.
- R8: Opcode 1101111 (JAL): `pc_sel`=1, `a_sel`=1, `b_sel`=1, `imm_sel`=3, `alu_sel`=add, `reg_wen`=1, `wb_sel`=2. The comparator flags have no effect.
- R9: Opcode 1100111 (JALR): `pc_sel`=1, `a_sel`=0, `b_sel`=1, `imm_sel`=0, `alu_sel`=add, `reg_wen`=1, `wb_sel`=2.
- R10: Opcode 0110111 (LUI): `imm_sel`=4, `b_sel`=1, `alu_sel`=pass-B (10), `reg_wen`=1, `wb_sel`=1.
- R11: Opcode 0010111 (AUIPC): `a_sel`=1, `b_sel`=1, `imm_sel`=4, `alu_sel`=add, `reg_wen`=1, `wb_sel`=1.
- R12: Any other opcode gives the following, whatever the other fields and flags are:
  - `reg_wen`=0, `mem_wr`=0, `pc_sel`=0, `br_unsigned`=0;
  - `a_sel`=0, `b_sel`=0, `imm_sel`=0, `alu_sel`=add, `wb_sel`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word being executed |
| br_eq | input | 1 | Comparator result: rs1 equals rs2 |
| br_lt | input | 1 | Comparator result: rs1 less than rs2 (signedness per `br_unsigned`) |
| pc_sel | output | 1 | Next-PC source |
| imm_sel | output | 3 | Immediate format for the generator |
| reg_wen | output | 1 | Register file write enable |
| br_unsigned | output | 1 | Request an unsigned comparison |
| a_sel | output | 1 | ALU operand A source |
| b_sel | output | 1 | ALU operand B source |
| alu_sel | output | 4 | ALU operation |
| mem_wr | output | 1 | Data memory direction |
| wb_sel | output | 2 | Register writeback source |

## Verification
Two effects can fall on the same instruction:
- A redirect of the PC and a register write land together on JAL and JALR, where the PC+4 link is written while the PC jumps. On branches, the redirect must come with no write at all.
- The bench provokes both cases by sweeping every opcode against every funct3, three funct7 patterns and all four comparator flag pairs.
- Each vector is judged on the full output word against a value that the bench derives from the tables above. This shows that the flags steer only branches and never disturb the write that goes with a jump.

// File: rtl/rvdec_pkg.sv
package rvdec_pkg;

    localparam int INSN_W = 32;
    localparam int OPC_W  = 7;
    localparam int F3_W   = 3;
    localparam int F7_W   = 7;

    localparam logic [OPC_W-1:0] OPC_REG    = 7'b0110011;
    localparam logic [OPC_W-1:0] OPC_IMM    = 7'b0010011;
    localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
    localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
    localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
    localparam logic [OPC_W-1:0] OPC_JAL    = 7'b1101111;
    localparam logic [OPC_W-1:0] OPC_JALR   = 7'b1100111;
    localparam logic [OPC_W-1:0] OPC_LUI    = 7'b0110111;
    localparam logic [OPC_W-1:0] OPC_AUIPC  = 7'b0010111;

    localparam logic [F7_W-1:0]  F7_ALT     = 7'b0100000;

    typedef enum logic [2:0] {
        IMM_I = 3'd0,
        IMM_S = 3'd1,
        IMM_B = 3'd2,
        IMM_J = 3'd3,
        IMM_U = 3'd4
    } imm_fmt_e;

    typedef enum logic [3:0] {
        ALU_ADD   = 4'd0,
        ALU_SUB   = 4'd1,
        ALU_SLL   = 4'd2,
        ALU_SLT   = 4'd3,
        ALU_SLTU  = 4'd4,
        ALU_XOR   = 4'd5,
        ALU_SRL   = 4'd6,
        ALU_SRA   = 4'd7,
        ALU_OR    = 4'd8,
        ALU_AND   = 4'd9,
        ALU_PASSB = 4'd10
    } alu_op_e;

    typedef enum logic [1:0] {
        WB_MEM = 2'd0,
        WB_ALU = 2'd1,
        WB_PC4 = 2'd2
    } wb_src_e;

    typedef enum logic [3:0] {
        CL_ILLEGAL,
        CL_REG,
        CL_IMM,
        CL_LOAD,
        CL_STORE,
        CL_BRANCH,
        CL_JAL,
        CL_JALR,
        CL_LUI,
        CL_AUIPC
    } op_class_e;

    typedef struct packed {
        logic     pc_sel;
        imm_fmt_e imm_sel;
        logic     reg_wen;
        logic     br_unsigned;
        logic     a_sel;
        logic     b_sel;
        alu_op_e  alu_sel;
        logic     mem_wr;
        wb_src_e  wb_sel;
    } ctrl_t;

endpackage

// File: rtl/rvdec_class.sv
module rvdec_class
    import rvdec_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output op_class_e        cls
);

    always_comb begin
        unique case (opcode)
            OPC_REG:    cls = CL_REG;
            OPC_IMM:    cls = CL_IMM;
            OPC_LOAD:   cls = CL_LOAD;
            OPC_STORE:  cls = CL_STORE;
            OPC_BRANCH: cls = CL_BRANCH;
            OPC_JAL:    cls = CL_JAL;
            OPC_JALR:   cls = CL_JALR;
            OPC_LUI:    cls = CL_LUI;
            OPC_AUIPC:  cls = CL_AUIPC;
            default:    cls = CL_ILLEGAL;
        endcase
    end

endmodule

// File: rtl/rvdec_alu.sv
module rvdec_alu
    import rvdec_pkg::*;
(
    input  op_class_e       cls,
    input  logic [F3_W-1:0] funct3,
    input  logic [F7_W-1:0] funct7,
    output alu_op_e         alu_op
);

    logic    alt_d;
    alu_op_e arith_d;

    always_comb begin
        alt_d = (funct7 == F7_ALT);
        unique case (funct3)
            3'b000:  arith_d = (alt_d && cls == CL_REG) ? ALU_SUB : ALU_ADD;
            3'b001:  arith_d = ALU_SLL;
            3'b010:  arith_d = ALU_SLT;
            3'b011:  arith_d = ALU_SLTU;
            3'b100:  arith_d = ALU_XOR;
            3'b101:  arith_d = alt_d ? ALU_SRA : ALU_SRL;
            3'b110:  arith_d = ALU_OR;
            default: arith_d = ALU_AND;
        endcase

        unique case (cls)
            CL_REG, CL_IMM: alu_op = arith_d;
            CL_LUI:         alu_op = ALU_PASSB;
            default:        alu_op = ALU_ADD;
        endcase
    end

    always_comb begin
        assert_sub_only_reg_R2 : assert (!(alu_op == ALU_SUB) || cls == CL_REG)
            else $error("sub selected outside register-register class");
    end

endmodule

// File: rtl/rvdec_branch.sv
module rvdec_branch
    import rvdec_pkg::*;
(
    input  logic            is_branch,
    input  logic [F3_W-1:0] funct3,
    input  logic            br_eq,
    input  logic            br_lt,
    output logic            taken,
    output logic            unsigned_cmp
);

    logic valid_d;
    logic cond_d;

    always_comb begin
        // funct3 010/011 are unused branch encodings
        valid_d      = funct3[2] | ~funct3[1];
        cond_d       = funct3[2] ? (br_lt ^ funct3[0]) : (br_eq ^ funct3[0]);
        taken        = is_branch & valid_d & cond_d;
        unsigned_cmp = is_branch & funct3[2] & funct3[1];
    end

    always_comb begin
        assert_taken_needs_branch_R6 : assert (!taken || is_branch)
            else $error("branch taken outside branch class");
        assert_unsigned_needs_branch_R7 : assert (!unsigned_cmp || is_branch)
            else $error("unsigned compare outside branch class");
    end

endmodule

// File: rtl/rvdec_top.sv
module rvdec_top
    import rvdec_pkg::*;
(
    input  logic [31:0] instr,
    input  logic        br_eq,
    input  logic        br_lt,
    output logic        pc_sel,
    output logic [2:0]  imm_sel,
    output logic        reg_wen,
    output logic        br_unsigned,
    output logic        a_sel,
    output logic        b_sel,
    output logic [3:0]  alu_sel,
    output logic        mem_wr,
    output logic [1:0]  wb_sel
);

    op_class_e cls;
    alu_op_e   alu_op;
    logic      br_taken;
    logic      br_uns;
    ctrl_t     ctrl_d;

    rvdec_class u_class (
        .opcode (instr[OPC_W-1:0]),
        .cls    (cls)
    );

    rvdec_alu u_alu (
        .cls    (cls),
        .funct3 (instr[14:12]),
        .funct7 (instr[31:25]),
        .alu_op (alu_op)
    );

    rvdec_branch u_branch (
        .is_branch    (cls == CL_BRANCH),
        .funct3       (instr[14:12]),
        .br_eq        (br_eq),
        .br_lt        (br_lt),
        .taken        (br_taken),
        .unsigned_cmp (br_uns)
    );

    always_comb begin
        ctrl_d             = '0;
        ctrl_d.imm_sel     = IMM_I;
        ctrl_d.alu_sel     = alu_op;
        ctrl_d.wb_sel      = WB_ALU;
        ctrl_d.br_unsigned = br_uns;
        unique case (cls)
            CL_REG: begin
                ctrl_d.reg_wen = 1'b1;
            end
            CL_IMM: begin
                ctrl_d.reg_wen = 1'b1;
                ctrl_d.b_sel   = 1'b1;
            end
            CL_LOAD: begin
                ctrl_d.reg_wen = 1'b1;
                ctrl_d.b_sel   = 1'b1;
                ctrl_d.wb_sel  = WB_MEM;
            end
            CL_STORE: begin
                ctrl_d.imm_sel = IMM_S;
                ctrl_d.b_sel   = 1'b1;
                ctrl_d.mem_wr  = 1'b1;
            end
            CL_BRANCH: begin
                ctrl_d.imm_sel = IMM_B;
                ctrl_d.a_sel   = 1'b1;
                ctrl_d.b_sel   = 1'b1;
                ctrl_d.pc_sel  = br_taken;
            end
            CL_JAL: begin
                ctrl_d.imm_sel = IMM_J;
                ctrl_d.a_sel   = 1'b1;
                ctrl_d.b_sel   = 1'b1;
                ctrl_d.pc_sel  = 1'b1;
                ctrl_d.reg_wen = 1'b1;
                ctrl_d.wb_sel  = WB_PC4;
            end
            CL_JALR: begin
                ctrl_d.b_sel   = 1'b1;
                ctrl_d.pc_sel  = 1'b1;
                ctrl_d.reg_wen = 1'b1;
                ctrl_d.wb_sel  = WB_PC4;
            end
            CL_LUI: begin
                ctrl_d.imm_sel = IMM_U;
                ctrl_d.b_sel   = 1'b1;
                ctrl_d.reg_wen = 1'b1;
            end
            CL_AUIPC: begin
                ctrl_d.imm_sel = IMM_U;
                ctrl_d.a_sel   = 1'b1;
                ctrl_d.b_sel   = 1'b1;
                ctrl_d.reg_wen = 1'b1;
            end
            default: begin
                ctrl_d = '0;
                ctrl_d.imm_sel = IMM_I;
                ctrl_d.alu_sel = ALU_ADD;
                ctrl_d.wb_sel  = WB_ALU;
            end
        endcase
    end

    assign pc_sel      = ctrl_d.pc_sel;
    assign imm_sel     = ctrl_d.imm_sel;
    assign reg_wen     = ctrl_d.reg_wen;
    assign br_unsigned = ctrl_d.br_unsigned;
    assign a_sel       = ctrl_d.a_sel;
    assign b_sel       = ctrl_d.b_sel;
    assign alu_sel     = ctrl_d.alu_sel;
    assign mem_wr      = ctrl_d.mem_wr;
    assign wb_sel      = ctrl_d.wb_sel;

    always_comb begin
        assert_illegal_safe_R12 : assert (cls != CL_ILLEGAL || (!reg_wen && !mem_wr && !pc_sel))
            else $error("unknown opcode produced a side effect");
        assert_store_no_write_R5 : assert (!mem_wr || !reg_wen)
            else $error("memory write together with register write");
        assert_link_with_jump_R8 : assert (wb_sel != WB_PC4 || (pc_sel && reg_wen))
            else $error("link writeback without redirect");
        assert_redirect_match_R6 : assert (cls != CL_BRANCH || pc_sel == br_taken)
            else $error("branch redirect disagrees with resolver");
    end

endmodule

// File: tb/rvdec_top_tb.sv
module rvdec_top_tb;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr = '0;
    logic        br_eq = 1'b0;
    logic        br_lt = 1'b0;
    logic        pc_sel, reg_wen, br_unsigned, a_sel, b_sel, mem_wr;
    logic [2:0]  imm_sel;
    logic [3:0]  alu_sel;
    logic [1:0]  wb_sel;

    int n_vec  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rvdec_top u_dut (
        .instr       (instr),
        .br_eq       (br_eq),
        .br_lt       (br_lt),
        .pc_sel      (pc_sel),
        .imm_sel     (imm_sel),
        .reg_wen     (reg_wen),
        .br_unsigned (br_unsigned),
        .a_sel       (a_sel),
        .b_sel       (b_sel),
        .alu_sel     (alu_sel),
        .mem_wr      (mem_wr),
        .wb_sel      (wb_sel)
    );

    // packed order: pc, imm[3], wen, bru, a, b, alu[4], mem, wb[2]
    function automatic logic [14:0] pack(input logic pc, input logic [2:0] im, input logic w,
                                         input logic u, input logic a, input logic b,
                                         input logic [3:0] al, input logic m, input logic [1:0] wb);
        return {pc, im, w, u, a, b, al, m, wb};
    endfunction

    function automatic logic [3:0] arith_op(input logic [2:0] f3, input logic [6:0] f7, input bit is_reg);
        bit alt = (f7 == 7'h20);
        case (f3)
            3'd0: return (alt && is_reg) ? 4'd1 : 4'd0;
            3'd1: return 4'd2;
            3'd2: return 4'd3;
            3'd3: return 4'd4;
            3'd4: return 4'd5;
            3'd5: return alt ? 4'd7 : 4'd6;
            3'd6: return 4'd8;
            default: return 4'd9;
        endcase
    endfunction

    task automatic expect_of(input logic [31:0] ins, input logic eq, input logic lt,
                             output logic [14:0] e, output string tag);
        logic [6:0] op = ins[6:0];
        logic [2:0] f3 = ins[14:12];
        logic [6:0] f7 = ins[31:25];
        logic tk;
        case (op)
            7'b0110011: begin e = pack(0,0,1,0,0,0,arith_op(f3,f7,1),0,1); tag = (f7 == 7'h20) ? "R2" : "R1"; end
            7'b0010011: begin e = pack(0,0,1,0,0,1,arith_op(f3,f7,0),0,1); tag = "R3"; end
            7'b0000011: begin e = pack(0,0,1,0,0,1,0,0,0); tag = "R4"; end
            7'b0100011: begin e = pack(0,1,0,0,0,1,0,1,1); tag = "R5"; end
            7'b1100011: begin
                case (f3)
                    3'd0: tk = eq;
                    3'd1: tk = !eq;
                    3'd4, 3'd6: tk = lt;
                    3'd5, 3'd7: tk = !lt;
                    default: tk = 0;
                endcase
                e = pack(tk,2,0,(f3 == 3'd6 || f3 == 3'd7),1,1,0,0,1);
                tag = (f3[2] & f3[1]) ? "R7" : "R6";
            end
            7'b1101111: begin e = pack(1,3,1,0,1,1,0,0,2); tag = "R8"; end
            7'b1100111: begin e = pack(1,0,1,0,0,1,0,0,2); tag = "R9"; end
            7'b0110111: begin e = pack(0,4,1,0,0,1,10,0,1); tag = "R10"; end
            7'b0010111: begin e = pack(0,4,1,0,1,1,0,0,1); tag = "R11"; end
            default:    begin e = pack(0,0,0,0,0,0,0,0,1); tag = "R12"; end
        endcase
    endtask

    task automatic apply_check(input logic [31:0] ins, input logic eq, input logic lt);
        logic [14:0] exp_v;
        logic [14:0] act_v;
        string tag;
        @(negedge clk);
        instr = ins;
        br_eq = eq;
        br_lt = lt;
        #(CLK_PERIOD/4);
        expect_of(ins, eq, lt, exp_v, tag);
        act_v = {pc_sel, imm_sel, reg_wen, br_unsigned, a_sel, b_sel, alu_sel, mem_wr, wb_sel};
        n_vec++;
        if (act_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s instr=%h eq=%0b lt=%0b actual=%h expected=%h", tag, ins, eq, lt, act_v, exp_v);
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        logic [6:0] f7s [3];
        f7s[0] = 7'h00;
        f7s[1] = 7'h20;
        f7s[2] = 7'h01;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // reset state: all-zero word is an unknown opcode, R12
        apply_check(32'h0, 1'b1, 1'b1);
        // full sweep: R1..R12 incl. R2 funct7 variants and R6/R7 flag pairs
        for (int op = 0; op < 128; op++)
            for (int f3 = 0; f3 < 8; f3++)
                for (int k = 0; k < 3; k++)
                    for (int fl = 0; fl < 4; fl++)
                        apply_check({f7s[k], 5'd3, 5'd2, 3'(f3), 5'd1, 7'(op)}, fl[1], fl[0]);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule